// File: doc/BRIEF.md
# Multi-Width Floating-Point Register File

This block is the operand store of a floating-point datapath: thirty-two 32-bit registers that can be read or written one word, two words or four words at a time. Each access carries a register number and a two-bit width code. A two-word value sits in a pair of registers that starts at an even number, and a four-word value sits in a group that starts at a multiple of four. In both cases the lowest-numbered register holds the most significant word. An access whose number breaks the alignment rule for its width, or whose width code is not one of the three defined ones, is flagged as an error and returns or stores nothing.

There are two independent read ports with registered outputs, one wide write port, and a one-word memory port. Memory loads deposit a word into a register, and stores read a word out for memory. The memory address is computed elsewhere and never enters this block. Software sees all three widths as views of the same storage, so a pair written as one double can be read back as two singles.

Top module: `fpreg_file`

## Requirements
- R1: After a synchronous reset every register reads as zero, and both read data buses, both read error flags, the write error flag and the store word are zero.
- R2: The width code is 00 for one word, 01 for two words and 10 for four words. A one-word read returns the register in bits [31:0] with bits [127:32] zero, one clock after the request.
- R3: A two-word access at even register n maps register n to bits [63:32] and register n+1 to bits [31:0]. On reads, bits [127:64] are zero.
- R4: A four-word access at register n (a multiple of four) maps register n to bits [127:96], n+1 to [95:64], n+2 to [63:32] and n+3 to [31:0].
- R5: Width code 11 is illegal. A read with it raises that port's error flag one clock later with all-zero data.
- R6: A two-word read at an odd number, or a four-word read at a number that is not a multiple of four, raises the port's error flag one clock later with all-zero data.
- R7: A write that is misaligned or uses code 11 raises the write error flag one clock later and changes no register.
- R8: A legal write updates every register it covers at the same clock edge.
- R9: A read requested in the same cycle as a write to the same register returns the contents from before that write.
- R10: The load port writes one 32-bit word into any register. The store port presents the named register's word on its output one clock after the request and holds it until the next request.
- R11: If the load port and the write port target the same register in one cycle, the loaded word is kept.
- R12: The two read ports act independently and can read different widths and registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A register number |
| ra_wid | input | 2 | Read port A width code |
| ra_data | output | 128 | Read port A data, registered |
| ra_err | output | 1 | Read port A alignment/width error |
| rb_idx | input | 5 | Read port B register number |
| rb_wid | input | 2 | Read port B width code |
| rb_data | output | 128 | Read port B data, registered |
| rb_err | output | 1 | Read port B alignment/width error |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register number |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 128 | Write data, laid out as on reads |
| wr_err | output | 1 | Previous write was rejected |
| ld_en | input | 1 | Load a memory word into a register |
| ld_idx | input | 5 | Load target register |
| ld_word | input | 32 | Word arriving from memory |
| st_en | input | 1 | Store request |
| st_idx | input | 5 | Store source register |
| st_word | output | 32 | Word leaving for memory, registered |

## Verification
The bench looks at the word order inside wide values: a design that swapped the pair or quad lanes would return a double written at 10 with its halves crossed when read back as two singles. It issues misaligned pair and quad accesses and code 11 on both reads and writes. A design that only masked the low bits would quietly read or overwrite neighbouring registers, and the bench catches this by reading those neighbours afterwards. It also covers a write and a read in the same cycle, and a load colliding with a wide write on the same register. Wrong forwarding or the wrong write priority shows up there as a stale or overwritten word.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  // Width codes carried on every access specifier.
  typedef enum logic [1:0] {
    FW_SGL = 2'b00,
    FW_DBL = 2'b01,
    FW_QUD = 2'b10,
    FW_BAD = 2'b11
  } fw_e;

  // Number of word lanes in the widest access; also the bank count.
  localparam int LANES = 4;
endpackage

// File: rtl/fpr_align.sv
// Decodes a register number and width code into a per-bank hit mask,
// the data lane each bank maps to, and an alignment/width error.
module fpr_align #(
  parameter int IW = 5
) (
  input  logic [IW-1:0]                  idx,
  input  logic [1:0]                     wid,
  output logic                           bad,
  output logic [fpr_pkg::LANES-1:0]      hit,
  output logic [fpr_pkg::LANES-1:0][1:0] lane
);
  import fpr_pkg::*;

  always_comb begin
    unique case (wid)
      FW_SGL:  bad = 1'b0;
      FW_DBL:  bad = idx[0];
      FW_QUD:  bad = |idx[1:0];
      default: bad = 1'b1;
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [1:0] BI = 2'(b);
    always_comb begin
      unique case (wid)
        FW_SGL: begin
          hit[b]  = (idx[1:0] == BI);
          lane[b] = 2'd0;
        end
        FW_DBL: begin
          hit[b]  = (idx[1] == BI[1]);
          lane[b] = {1'b0, ~BI[0]};
        end
        FW_QUD: begin
          hit[b]  = 1'b1;
          lane[b] = 2'd3 - BI;
        end
        default: begin
          hit[b]  = 1'b0;
          lane[b] = 2'd0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpr_bank.sv
// One storage bank: holds every register whose number has the bank's
// value in its two low bits. Two write ports (B wins on a collision),
// three combinational read ports.
module fpr_bank #(
  parameter int ROWS   = 8,
  parameter int WORD_W = 32,
  parameter int NRD    = 3,
  localparam int RW    = $clog2(ROWS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wa_en,
  input  logic [RW-1:0]              wa_row,
  input  logic [WORD_W-1:0]          wa_din,
  input  logic                       wb_en,
  input  logic [RW-1:0]              wb_row,
  input  logic [WORD_W-1:0]          wb_din,
  input  logic [NRD-1:0][RW-1:0]     rrow,
  output logic [NRD-1:0][WORD_W-1:0] rq
);
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      if (wa_en) mem[wa_row] <= wa_din;
      if (wb_en) mem[wb_row] <= wb_din;
    end
  end

  always_comb begin
    for (int p = 0; p < NRD; p++) rq[p] = mem[rrow[p]];
  end

  // R11: a load colliding with a wide write on one row keeps the load.
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en && wa_row == wb_row) |=> mem[$past(wb_row)] == $past(wb_din));
endmodule

// File: rtl/fpr_rdport.sv
// One read port: gathers the bank words of the addressed row into the
// lane layout for the requested width and registers the result.
module fpr_rdport #(
  parameter int IW     = 5,
  parameter int WORD_W = 32,
  localparam int DW    = fpr_pkg::LANES * WORD_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [IW-1:0]                         idx,
  input  logic [1:0]                            wid,
  input  logic [fpr_pkg::LANES-1:0][WORD_W-1:0] words,
  output logic [DW-1:0]                         data_q,
  output logic                                  err_q
);
  import fpr_pkg::*;

  logic                   bad;
  logic [LANES-1:0]       hit;
  logic [LANES-1:0][1:0]  lane;
  logic [DW-1:0]          nxt;

  fpr_align #(.IW(IW)) u_al (
    .idx (idx),
    .wid (wid),
    .bad (bad),
    .hit (hit),
    .lane(lane)
  );

  always_comb begin
    nxt = '0;
    if (!bad) begin
      for (int b = 0; b < LANES; b++) begin
        if (hit[b]) nxt[int'(lane[b])*WORD_W +: WORD_W] = words[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      data_q <= nxt;
      err_q  <= bad;
    end
  end

  // R5: the spare width code is always refused.
  assert_bad_code_R5: assert property (@(posedge clk) disable iff (rst)
    (wid == FW_BAD) |=> (err_q && data_q == '0));

  // R6: odd pair or unaligned quad is refused with zero data.
  assert_misalign_R6: assert property (@(posedge clk) disable iff (rst)
    ((wid == FW_DBL && idx[0]) || (wid == FW_QUD && idx[1:0] != 2'b00))
      |=> (err_q && data_q == '0));

  // R2: a single-word read leaves the upper lanes clear.
  assert_single_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (wid == FW_SGL) |=> (!err_q && data_q[DW-1:WORD_W] == '0));

  // R3: a pair read leaves the upper half clear.
  assert_pair_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wid == FW_DBL) |=> (data_q[DW-1:2*WORD_W] == '0));
endmodule

// File: rtl/fpreg_file.sv
// Thirty-two word floating-point register file with single, pair and
// quad views, two read ports, one write port and a load/store port.
module fpreg_file #(
  parameter int NREG   = 32,
  parameter int WORD_W = 32,
  localparam int IW    = $clog2(NREG),
  localparam int NB    = fpr_pkg::LANES,
  localparam int ROWS  = NREG / NB,
  localparam int RW    = $clog2(ROWS),
  localparam int DW    = NB * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     ra_idx,
  input  logic [1:0]        ra_wid,
  output logic [DW-1:0]     ra_data,
  output logic              ra_err,
  input  logic [IW-1:0]     rb_idx,
  input  logic [1:0]        rb_wid,
  output logic [DW-1:0]     rb_data,
  output logic              rb_err,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [1:0]        wr_wid,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_err,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              st_en,
  input  logic [IW-1:0]     st_idx,
  output logic [WORD_W-1:0] st_word
);
  import fpr_pkg::*;

  logic                   w_bad;
  logic [NB-1:0]          w_hit;
  logic [NB-1:0][1:0]     w_lane;
  logic [NB-1:0]          we_vec;
  logic [NB-1:0][WORD_W-1:0] ra_words, rb_words, st_words;

  fpr_align #(.IW(IW)) u_wal (
    .idx (wr_idx),
    .wid (wr_wid),
    .bad (w_bad),
    .hit (w_hit),
    .lane(w_lane)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [1:0] BI = 2'(b);
    logic [2:0][RW-1:0]     rrow;
    logic [2:0][WORD_W-1:0] rq;
    logic [WORD_W-1:0]      din_a;

    assign we_vec[b] = wr_en && !w_bad && w_hit[b];
    assign din_a     = wr_data[int'(w_lane[b])*WORD_W +: WORD_W];
    assign rrow      = {st_idx[IW-1:2], rb_idx[IW-1:2], ra_idx[IW-1:2]};

    fpr_bank #(.ROWS(ROWS), .WORD_W(WORD_W), .NRD(3)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wa_en (we_vec[b]),
      .wa_row(wr_idx[IW-1:2]),
      .wa_din(din_a),
      .wb_en (ld_en && ld_idx[1:0] == BI),
      .wb_row(ld_idx[IW-1:2]),
      .wb_din(ld_word),
      .rrow  (rrow),
      .rq    (rq)
    );

    assign ra_words[b] = rq[0];
    assign rb_words[b] = rq[1];
    assign st_words[b] = rq[2];
  end

  fpr_rdport #(.IW(IW), .WORD_W(WORD_W)) u_rda (
    .clk(clk), .rst(rst), .idx(ra_idx), .wid(ra_wid),
    .words(ra_words), .data_q(ra_data), .err_q(ra_err)
  );

  fpr_rdport #(.IW(IW), .WORD_W(WORD_W)) u_rdb (
    .clk(clk), .rst(rst), .idx(rb_idx), .wid(rb_wid),
    .words(rb_words), .data_q(rb_data), .err_q(rb_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err  <= 1'b0;
      st_word <= '0;
    end else begin
      wr_err <= wr_en && w_bad;
      if (st_en) st_word <= st_words[st_idx[1:0]];
    end
  end

  // R7: a refused write enables no bank.
  assert_bad_write_inert_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_wid == FW_BAD || (wr_wid == FW_DBL && wr_idx[0]) ||
               (wr_wid == FW_QUD && wr_idx[1:0] != 2'b00))) |-> (we_vec == '0));

  // R8: a legal quad write reaches all banks in the same edge.
  assert_quad_all_banks_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wid == FW_QUD && wr_idx[1:0] == 2'b00) |-> (&we_vec));

  // R8: a legal pair write enables exactly two banks.
  assert_pair_two_banks_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wid == FW_DBL && !wr_idx[0]) |-> ($countones(we_vec) == 2));
endmodule

// File: tb/sim_fpreg_file.sv
`timescale 1ns/1ps
module sim_fpreg_file;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   ra_idx = '0, rb_idx = '0, wr_idx = '0, ld_idx = '0, st_idx = '0;
  logic [1:0]   ra_wid = '0, rb_wid = '0, wr_wid = '0;
  logic [127:0] ra_data, rb_data, wr_data = '0;
  logic         ra_err, rb_err, wr_err;
  logic         wr_en = 1'b0, ld_en = 1'b0, st_en = 1'b0;
  logic [31:0]  ld_word = '0, st_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [32];

  always #2.5 clk = ~clk;

  fpreg_file u0 (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_wid(ra_wid), .ra_data(ra_data), .ra_err(ra_err),
    .rb_idx(rb_idx), .rb_wid(rb_wid), .rb_data(rb_data), .rb_err(rb_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data), .wr_err(wr_err),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .st_en(st_en), .st_idx(st_idx), .st_word(st_word)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(int idx, logic [1:0] w);
    return (w == 2'b11) || (w == 2'b01 && idx % 2 != 0) || (w == 2'b10 && idx % 4 != 0);
  endfunction

  function automatic logic [127:0] expv(int idx, logic [1:0] w);
    logic [127:0] r = '0;
    if (is_bad(idx, w)) return r;
    case (w)
      2'b00: r[31:0] = mdl[idx];
      2'b01: r[63:0] = {mdl[idx], mdl[idx+1]};
      default: r = {mdl[idx], mdl[idx+1], mdl[idx+2], mdl[idx+3]};
    endcase
    return r;
  endfunction

  function automatic void put(int idx, logic [1:0] w, logic [127:0] d);
    if (is_bad(idx, w)) return;
    case (w)
      2'b00: mdl[idx] = d[31:0];
      2'b01: begin mdl[idx] = d[63:32]; mdl[idx+1] = d[31:0]; end
      default: for (int k = 0; k < 4; k++) mdl[idx+k] = d[127-32*k -: 32];
    endcase
  endfunction

  task automatic do_write(string req, int idx, logic [1:0] w, logic [127:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_wid = w; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    chk({req, " wr_err"}, 128'(wr_err), 128'(is_bad(idx, w)));
    put(idx, w, d);
  endtask

  task automatic rd2(string req, int ia, logic [1:0] wa, int ib, logic [1:0] wb);
    logic [127:0] ea, eb;
    @(negedge clk);
    ra_idx = 5'(ia); ra_wid = wa; rb_idx = 5'(ib); rb_wid = wb;
    ea = expv(ia, wa); eb = expv(ib, wb);
    @(negedge clk);
    chk({req, " A data"}, ra_data, ea);
    chk({req, " A err"}, 128'(ra_err), 128'(is_bad(ia, wa)));
    chk({req, " B data"}, rb_data, eb);
    chk({req, " B err"}, 128'(rb_err), 128'(is_bad(ib, wb)));
  endtask

  task automatic t_reset();
    chk("R1 ra_data", ra_data, '0);
    chk("R1 rb_data", rb_data, '0);
    chk("R1 errs", 128'({ra_err, rb_err, wr_err}), '0);
    chk("R1 st_word", 128'(st_word), '0);
    rd2("R1 regs", 0, 2'b10, 28, 2'b10);
  endtask

  task automatic t_single();
    do_write("R2", 5, 2'b00, 128'h1111_2222_3333_4444_5555_6666_7777_ABCD);
    rd2("R2 single", 5, 2'b00, 4, 2'b00);
  endtask

  task automatic t_double();
    do_write("R3", 10, 2'b01, 128'hDEAD_BEEF_0123_4567);
    rd2("R3 halves", 10, 2'b00, 11, 2'b00);
    rd2("R3 pair", 10, 2'b01, 8, 2'b01);
  endtask

  task automatic t_quad();
    do_write("R4 R8", 16, 2'b10, 128'hA0A0_0001_B0B0_0002_C0C0_0003_D0D0_0004);
    rd2("R4 words01", 16, 2'b00, 17, 2'b00);
    rd2("R4 words23", 18, 2'b00, 19, 2'b00);
    rd2("R8 quad", 16, 2'b10, 18, 2'b01);
  endtask

  task automatic t_misalign();
    rd2("R6 odd pair", 11, 2'b01, 18, 2'b10);
    rd2("R6 quad off", 17, 2'b10, 19, 2'b10);
    rd2("R5 code11", 16, 2'b11, 10, 2'b01);
  endtask

  task automatic t_badwrite();
    do_write("R7 odd pair", 17, 2'b01, 128'hFFFF_FFFF_FFFF_FFFF);
    rd2("R7 pair intact", 16, 2'b10, 17, 2'b00);
    do_write("R7 quad off", 18, 2'b10, '1);
    do_write("R7 code11", 5, 2'b11, '1);
    rd2("R7 regs intact", 16, 2'b10, 5, 2'b00);
  endtask

  task automatic t_rbw();
    logic [127:0] old;
    @(negedge clk);
    old = expv(10, 2'b01);
    wr_en = 1; wr_idx = 10; wr_wid = 2'b01; wr_data = 128'h5A5A_5A5A_A5A5_A5A5;
    ra_idx = 10; ra_wid = 2'b01;
    @(negedge clk);
    wr_en = 0;
    chk("R9 old value", ra_data, old);
    put(10, 2'b01, 128'h5A5A_5A5A_A5A5_A5A5);
    rd2("R9 new value", 10, 2'b01, 11, 2'b00);
  endtask

  task automatic t_ldst();
    @(negedge clk);
    ld_en = 1; ld_idx = 9; ld_word = 32'hCAFE_F00D;
    @(negedge clk);
    ld_en = 0; mdl[9] = 32'hCAFE_F00D;
    st_en = 1; st_idx = 9;
    @(negedge clk);
    st_en = 0; st_idx = 10;
    chk("R10 store word", 128'(st_word), 128'(mdl[9]));
    @(negedge clk);
    chk("R10 store held", 128'(st_word), 128'(mdl[9]));
    rd2("R10 load read", 9, 2'b00, 8, 2'b01);
  endtask

  task automatic t_collide();
    @(negedge clk);
    wr_en = 1; wr_idx = 20; wr_wid = 2'b10; wr_data = 128'h1_0000_0002_0000_0003_0000_0004;
    ld_en = 1; ld_idx = 21; ld_word = 32'h7777_0021;
    @(negedge clk);
    wr_en = 0; ld_en = 0;
    put(20, 2'b10, 128'h1_0000_0002_0000_0003_0000_0004);
    mdl[21] = 32'h7777_0021;
    rd2("R11 quad+load", 20, 2'b10, 21, 2'b00);
  endtask

  task automatic t_dual();
    rd2("R12 mixed", 16, 2'b10, 5, 2'b00);
    rd2("R12 swap", 10, 2'b01, 20, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single();
    t_double();
    t_quad();
    t_misalign();
    t_badwrite();
    t_rbw();
    t_ldst();
    t_collide();
    t_dual();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule